// File: doc/BRIEF.md
# Zoned Bandwidth Monitor

This block measures bus traffic over a programmable sampling window. Every clock in which a transfer strobe is high adds that beat's byte count to a running total. When the window closes, the total is converted to count units by a right shift and clipped to 12 bits. The result is then compared with three programmable thresholds, which place the window in one of four zones numbered 0 (lightest) to 3 (heaviest).

Landing in a zone runs that zone's action field. The field can increment or clear the 8-bit hit counter of any zone. When a zone's hit counter reaches its programmed limit, a sticky status bit for that zone is set. The enabled status bits are ORed onto a local interrupt line. A latched, separately enabled global line follows that local line. The block also keeps, for each zone, the largest window count classified into it. Software programs the block and reads it back through a single-cycle register port with word addresses.

The window length is given in clock ticks of the sampling clock. The window field is `WIN_W` bits wide: 24 by default, and 20 is also supported. The count unit is 2^`UNIT_SHIFT` bytes.

Top module: `zbw_monitor`

## Requirements
- R1: After reset, every readable register reads 0 and both interrupt lines are low. Register word addresses are: 0 run, 1 counter clear, 2 window, 3 low, 4 medium, 5 high, 6 actions, 7 hit limits, 8 status, 9 interrupt enable, 10 status clear, 11 global enable, 12 global clear, 16+z max of zone z.
- R2: A window lasts N ticks, where N is the value of the window field, and 0 is treated as 1. Its count is (bytes in window) >> `UNIT_SHIFT`, clipped to 4095. Write bits at and above `WIN_W` in the window field are dropped.
- R3: The zone is 3 if count >= high, otherwise 2 if count >= medium, otherwise 1 if count >= low, otherwise 0. A count equal to a threshold goes to the higher zone.
- R4: The action field for zone z sits at bits [8z+7:8z]. Within it, the slot for target t sits at bits [2t+1:2t]. Slot value 2'b10 increments t's hit counter, saturating at 255. Slot value 2'b01 clears it. Other values leave it unchanged.
- R5: The hit limit for zone t sits at bits [8t+7:8t]. Status bit t is set on a window event after which t's hit counter is >= the limit. A limit of 0xFF never sets status.
- R6: Each zone's max register keeps the largest count classified into that zone. It is lowered only by a clear-all.
- R7: Writing counter-clear bit 0 zeroes the hit counters, the byte total and the window timer. It also drops a window result that is classified in the same cycle. Bit 1 does all of that and also zeroes the max registers. The register reads 0.
- R8: Status bits are sticky and are cleared by writing 1s to the status-clear address, which reads 0. A set and a clear of the same bit in the same cycle leave the bit set. The local line is OR(status AND enable).
- R9: A global pending flag is set while the local line is high. Writing global clear bit 0 reloads the flag from the current local line. The global line is the flag AND global-enable bit 0. The global-clear address reads 0.
- R10: While run bit 0 is 0, the window timer and byte total are held at zero and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one window tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | A transfer beat occurs this cycle |
| xfer_bytes | input | BYTE_W | Bytes moved by this beat |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_local | output | 1 | OR of enabled zone status bits |
| irq_global | output | 1 | Latched global interrupt |

## Verification
The window result is classified on the clock edge after the window closes. A software write can land on that same edge. The bench provokes this in two ways. It writes the status clear exactly on the classification edge, and the zone's bit must read back as set. It writes the counter clear on that same edge, and the window must leave no trace in either the status or the max register. A vector table sweeps counts below, equal to and above each threshold. Directed runs then exercise the cross-zone clearing action, the 0xFF limit, saturation, and the order in which local and global clears are applied.

// File: rtl/zbw_pkg.sv
package zbw_pkg;
  localparam int NZ    = 4;
  localparam int CNT_W = 12;
  localparam int HIT_W = 8;
  localparam int FLD_W = 8;
  localparam int AW    = 5;
  localparam int DW    = 32;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [HIT_W-1:0] hit_t;
  typedef logic [1:0]       zone_t;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_INC  = 2'b10,
    ACT_RSV  = 2'b11
  } act_e;

  typedef struct packed {
    cnt_t lo;
    cnt_t mid;
    cnt_t hi;
  } thr_t;

  localparam logic [AW-1:0] A_RUN  = 5'd0;
  localparam logic [AW-1:0] A_CCLR = 5'd1;
  localparam logic [AW-1:0] A_WIN  = 5'd2;
  localparam logic [AW-1:0] A_TLO  = 5'd3;
  localparam logic [AW-1:0] A_TMID = 5'd4;
  localparam logic [AW-1:0] A_THI  = 5'd5;
  localparam logic [AW-1:0] A_ACT  = 5'd6;
  localparam logic [AW-1:0] A_LIM  = 5'd7;
  localparam logic [AW-1:0] A_IST  = 5'd8;
  localparam logic [AW-1:0] A_IEN  = 5'd9;
  localparam logic [AW-1:0] A_ICLR = 5'd10;
  localparam logic [AW-1:0] A_GEN  = 5'd11;
  localparam logic [AW-1:0] A_GCLR = 5'd12;
  localparam logic [AW-1:0] A_MAX0 = 5'd16;
endpackage

// File: rtl/zbw_regs.sv
module zbw_regs
  import zbw_pkg::*;
#(
  parameter int WIN_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  input  logic [NZ-1:0]       status,
  input  logic [NZ*CNT_W-1:0] zmax,
  output logic [DW-1:0]       rdata,
  output logic                run,
  output logic [WIN_W-1:0]    win_len,
  output thr_t                thr,
  output logic [DW-1:0]       act,
  output logic [DW-1:0]       lim,
  output logic [NZ-1:0]       ien,
  output logic                gien,
  output logic                clr_cnt,
  output logic                clr_all,
  output logic [NZ-1:0]       iclr,
  output logic                gclr
);
  localparam int WPAD = DW - WIN_W;

  logic             run_q, run_d;
  logic [WIN_W-1:0] win_q, win_d;
  thr_t             thr_q, thr_d;
  logic [DW-1:0]    act_q, act_d;
  logic [DW-1:0]    lim_q, lim_d;
  logic [NZ-1:0]    ien_q, ien_d;
  logic             gien_q, gien_d;

  always_comb begin
    run_d  = run_q;
    win_d  = win_q;
    thr_d  = thr_q;
    act_d  = act_q;
    lim_d  = lim_q;
    ien_d  = ien_q;
    gien_d = gien_q;
    if (we) begin
      unique case (addr)
        A_RUN:   run_d     = wdata[0];
        A_WIN:   win_d     = wdata[WIN_W-1:0];
        A_TLO:   thr_d.lo  = wdata[CNT_W-1:0];
        A_TMID:  thr_d.mid = wdata[CNT_W-1:0];
        A_THI:   thr_d.hi  = wdata[CNT_W-1:0];
        A_ACT:   act_d     = wdata;
        A_LIM:   lim_d     = wdata;
        A_IEN:   ien_d     = wdata[NZ-1:0];
        A_GEN:   gien_d    = wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      win_q  <= '0;
      thr_q  <= '0;
      act_q  <= '0;
      lim_q  <= '0;
      ien_q  <= '0;
      gien_q <= 1'b0;
    end else if (we) begin
      run_q  <= run_d;
      win_q  <= win_d;
      thr_q  <= thr_d;
      act_q  <= act_d;
      lim_q  <= lim_d;
      ien_q  <= ien_d;
      gien_q <= gien_d;
    end
  end

  // Write-only strobes act on the edge that takes the write.
  assign clr_cnt = we && (addr == A_CCLR) && (wdata[0] || wdata[1]);
  assign clr_all = we && (addr == A_CCLR) && wdata[1];
  assign iclr    = (we && (addr == A_ICLR)) ? wdata[NZ-1:0] : '0;
  assign gclr    = we && (addr == A_GCLR) && wdata[0];

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_RUN:  rdata[0]         = run_q;
      A_WIN:  rdata            = {{WPAD{1'b0}}, win_q};
      A_TLO:  rdata[CNT_W-1:0] = thr_q.lo;
      A_TMID: rdata[CNT_W-1:0] = thr_q.mid;
      A_THI:  rdata[CNT_W-1:0] = thr_q.hi;
      A_ACT:  rdata            = act_q;
      A_LIM:  rdata            = lim_q;
      A_IST:  rdata[NZ-1:0]    = status;
      A_IEN:  rdata[NZ-1:0]    = ien_q;
      A_GEN:  rdata[0]         = gien_q;
      default: begin
        if (addr[4] && (addr[3:2] == 2'b00))
          rdata[CNT_W-1:0] = zmax[addr[1:0]*CNT_W +: CNT_W];
      end
    endcase
  end

  assign run     = run_q;
  assign win_len = win_q;
  assign thr     = thr_q;
  assign act     = act_q;
  assign lim     = lim_q;
  assign ien     = ien_q;
  assign gien    = gien_q;
endmodule

// File: rtl/zbw_window.sv
module zbw_window
  import zbw_pkg::*;
#(
  parameter int WIN_W      = 24,
  parameter int BYTE_W     = 8,
  parameter int UNIT_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [WIN_W-1:0]  win_len,
  input  logic              xfer_valid,
  input  logic [BYTE_W-1:0] xfer_bytes,
  output logic              done,
  output cnt_t              cnt
);
  localparam int ACC_W = BYTE_W + WIN_W + 1;
  localparam logic [ACC_W-1:0] CNT_CAP = ACC_W'((1 << CNT_W) - 1);

  logic [WIN_W-1:0] tmr_q, tmr_d, last_tick;
  logic [ACC_W-1:0] acc_q, acc_d, sum, units;
  logic             done_q, done_d, at_end;
  cnt_t             cnt_q, cnt_d;

  assign last_tick = (win_len == '0) ? '0 : win_len - 1'b1;
  assign at_end    = (tmr_q >= last_tick);
  assign sum       = acc_q + (xfer_valid ? ACC_W'(xfer_bytes) : '0);
  assign units     = sum >> UNIT_SHIFT;

  always_comb begin
    tmr_d  = tmr_q + 1'b1;
    acc_d  = sum;
    done_d = 1'b0;
    cnt_d  = (units > CNT_CAP) ? CNT_CAP[CNT_W-1:0] : units[CNT_W-1:0];
    if (!run || clr) begin
      tmr_d = '0;
      acc_d = '0;
    end else if (at_end) begin
      tmr_d  = '0;
      acc_d  = '0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      tmr_q  <= tmr_d;
      acc_q  <= acc_d;
      done_q <= done_d;
      if (done_d) cnt_q <= cnt_d;
    end
  end

  assign done = done_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/zbw_zone_engine.sv
module zbw_zone_engine
  import zbw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                clr_cnt,
  input  logic                clr_all,
  input  cnt_t                cnt,
  input  thr_t                thr,
  input  logic [DW-1:0]       act,
  input  logic [DW-1:0]       lim,
  input  logic [NZ-1:0]       iclr,
  output logic [NZ-1:0]       status,
  output logic [NZ*CNT_W-1:0] zmax,
  output logic [NZ*HIT_W-1:0] hits
);
  zone_t            zone;
  logic [FLD_W-1:0] fld;
  logic             apply;

  always_comb begin
    if (cnt >= thr.hi)       zone = 2'd3;
    else if (cnt >= thr.mid) zone = 2'd2;
    else if (cnt >= thr.lo)  zone = 2'd1;
    else                     zone = 2'd0;
  end

  assign fld   = act[FLD_W*zone +: FLD_W];
  assign apply = go && !clr_cnt;

  for (genvar t = 0; t < NZ; t++) begin : g_zone
    hit_t  hit_q, hit_d, limit;
    cnt_t  max_q, max_d;
    logic  st_q, st_d, reach;
    act_e  slot;

    assign slot  = act_e'(fld[2*t +: 2]);
    assign limit = lim[HIT_W*t +: HIT_W];

    always_comb begin
      hit_d = hit_q;
      if (clr_cnt) begin
        hit_d = '0;
      end else if (go) begin
        unique case (slot)
          ACT_CLR: hit_d = '0;
          ACT_INC: hit_d = (hit_q == '1) ? hit_q : hit_q + 1'b1;
          default: hit_d = hit_q;
        endcase
      end
    end

    assign reach = apply && (hit_d >= limit) && (limit != '1);
    assign st_d  = (st_q && !iclr[t]) || reach;

    always_comb begin
      max_d = max_q;
      if (clr_all)
        max_d = '0;
      else if (apply && (zone == zone_t'(t)) && (cnt > max_q))
        max_d = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q <= '0;
        max_q <= '0;
        st_q  <= 1'b0;
      end else begin
        hit_q <= hit_d;
        max_q <= max_d;
        st_q  <= st_d;
      end
    end

    assign status[t]                = st_q;
    assign zmax[t*CNT_W +: CNT_W]   = max_q;
    assign hits[t*HIT_W +: HIT_W]   = hit_q;
  end
endmodule

// File: rtl/zbw_monitor.sv
module zbw_monitor
  import zbw_pkg::*;
#(
  parameter int WIN_W      = 24,
  parameter int BYTE_W     = 8,
  parameter int UNIT_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_valid,
  input  logic [BYTE_W-1:0] xfer_bytes,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_local,
  output logic              irq_global
);
  logic                run, gien, clr_cnt, clr_all, gclr, win_done, win_go;
  logic [WIN_W-1:0]    win_len;
  thr_t                thr;
  logic [DW-1:0]       act, lim;
  logic [NZ-1:0]       ien, iclr, status;
  logic [NZ*CNT_W-1:0] zmax;
  logic [NZ*HIT_W-1:0] hits;
  cnt_t                win_cnt;
  logic                gpend_q, gpend_d;

  zbw_regs #(.WIN_W(WIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .status(status), .zmax(zmax), .rdata(reg_rdata), .run(run),
    .win_len(win_len), .thr(thr), .act(act), .lim(lim), .ien(ien),
    .gien(gien), .clr_cnt(clr_cnt), .clr_all(clr_all), .iclr(iclr),
    .gclr(gclr)
  );

  zbw_window #(.WIN_W(WIN_W), .BYTE_W(BYTE_W), .UNIT_SHIFT(UNIT_SHIFT)) u_win (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr_cnt), .win_len(win_len),
    .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes), .done(win_done),
    .cnt(win_cnt)
  );

  assign win_go = win_done && run;

  zbw_zone_engine u_eng (
    .clk(clk), .rst_n(rst_n), .go(win_go), .clr_cnt(clr_cnt),
    .clr_all(clr_all), .cnt(win_cnt), .thr(thr), .act(act), .lim(lim),
    .iclr(iclr), .status(status), .zmax(zmax), .hits(hits)
  );

  assign irq_local = |(status & ien);
  assign gpend_d   = gclr ? irq_local : (gpend_q || irq_local);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gpend_q <= 1'b0;
    else        gpend_q <= gpend_d;
  end

  assign irq_global = gpend_q && gien;
endmodule

// File: rtl/zbw_monitor_chk.sv
module zbw_monitor_chk
  import zbw_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                run,
  input logic                go,
  input logic                clr_cnt,
  input logic                clr_all,
  input logic [NZ-1:0]       iclr,
  input logic [NZ-1:0]       status,
  input logic [NZ*HIT_W-1:0] hits,
  input logic [NZ*CNT_W-1:0] zmax,
  input logic                irq_local,
  input logic                irq_global,
  input logic                gien
);
  // R8: without a clear write, no status bit falls
  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iclr == '0) |=> ((status & $past(status)) == $past(status)));

  // R10: no new status while monitoring is stopped
  p_quiet_when_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((status & ~$past(status)) == '0));

  // R4: hit counters move only on a window event or a counter clear
  p_hits_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !clr_cnt) |=> $stable(hits));

  // R9: the global line rises only from a high local line or an enable change
  p_global_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_global) |-> ($past(irq_local) || !$past(gien)));

  // R6: max registers never fall except through clear-all
  for (genvar z = 0; z < NZ; z++) begin : g_max
    p_max_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_all |=> (zmax[z*CNT_W +: CNT_W] >= $past(zmax[z*CNT_W +: CNT_W])));
  end
endmodule

bind zbw_monitor zbw_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .go(win_go), .clr_cnt(clr_cnt),
  .clr_all(clr_all), .iclr(iclr), .status(status), .hits(hits), .zmax(zmax),
  .irq_local(irq_local), .irq_global(irq_global), .gien(gien)
);

// File: tb/zbw_monitor_bench.sv
module zbw_monitor_bench;
  import zbw_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        xfer_valid;
  logic [7:0]  xfer_bytes;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, rv;
  logic        irq_local, irq_global;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  zbw_monitor u_zbw_monitor (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_local(irq_local), .irq_global(irq_global)
  );

  localparam int NV = 7;
  localparam int WLEN = 16;
  localparam int VB [NV] = '{20, 40, 80, 160, 255, 76, 0};
  localparam int VZ [NV] = '{0, 1, 2, 3, 3, 1, 0};

  function automatic int exp_cnt(int b, int w);
    int u = (b * w) / 64;
    return (u > 4095) ? 4095 : u;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run_windows(int b, int n);
    xfer_bytes = 8'(b); xfer_valid = 1'b1;
    wr(A_RUN, 1);
    repeat (WLEN * n + 4) @(negedge clk);
    wr(A_RUN, 0);
  endtask

  task automatic base_cfg(logic [31:0] actv, logic [31:0] limv);
    wr(A_RUN, 0);
    wr(A_WIN, WLEN);
    wr(A_TLO, 10); wr(A_TMID, 20); wr(A_THI, 40);
    wr(A_ACT, actv); wr(A_LIM, limv);
    wr(A_IEN, 4'hF);
    wr(A_CCLR, 3);
    wr(A_ICLR, 4'hF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; xfer_valid = 1'b0; xfer_bytes = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    for (int a = 0; a < 20; a++) begin
      if (a < 13 || a >= 16) begin
        rd(5'(a), rv);
        check("R1 reset read", rv, 0);
      end
    end
    check("R1 irq_local reset", 32'(irq_local), 0);
    check("R1 irq_global reset", 32'(irq_global), 0);

    // R2: window field width
    @(negedge clk);
    wr(A_WIN, 32'hFF00_0010);
    rd(A_WIN, rv);
    check("R2 window upper bits dropped", rv, 32'h0000_0010);

    // Table: R3 zoning (equality goes upward), R2 counts
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      base_cfg(32'h8020_0802, 32'h0101_0101);
      run_windows(VB[i], 1);
      rd(A_IST, rv);
      check("R3 zone status", rv, 32'(1 << VZ[i]));
      rd(5'(A_MAX0 + VZ[i]), rv);
      check("R2 window count in max", rv, 32'(exp_cnt(VB[i], WLEN)));
      check("R8 local line", 32'(irq_local), 1);
    end

    // R2: saturation at 4095
    @(negedge clk);
    base_cfg(32'h8020_0802, 32'h0101_0101);
    wr(A_WIN, 2000);
    xfer_bytes = 8'd255; xfer_valid = 1'b1;
    wr(A_RUN, 1);
    repeat (2006) @(negedge clk);
    wr(A_RUN, 0);
    rd(5'(A_MAX0 + 3), rv);
    check("R2 count saturates", rv, 32'(exp_cnt(255, 2000)));

    // R4/R5: zone 0 clears zone 1 hits; zone 1 increments itself; limit 3
    @(negedge clk);
    base_cfg(32'h0000_0804, 32'hFFFF_03FF);
    run_windows(40, 2);
    rd(A_IST, rv);
    check("R5 below limit no status", rv, 0);
    run_windows(0, 1);
    run_windows(40, 2);
    rd(A_IST, rv);
    check("R4 cross-zone clear restarts count", rv, 0);
    run_windows(40, 1);
    rd(A_IST, rv);
    check("R5 limit reached, 0xFF zone silent", rv, 32'h2);

    // R8: enable masking and write-one-to-clear
    wr(A_IEN, 4'h1);
    check("R8 masked status", 32'(irq_local), 0);
    wr(A_IEN, 4'h2);
    check("R8 enabled status", 32'(irq_local), 1);
    wr(A_ICLR, 4'h1);
    rd(A_IST, rv);
    check("R8 clear other bit keeps status", rv, 32'h2);
    wr(A_ICLR, 4'h2);
    rd(A_IST, rv);
    check("R8 w1c clears status", rv, 0);

    // R6/R7: counter clear keeps max, clear-all drops it
    rd(5'(A_MAX0 + 1), rv);
    check("R6 max held", rv, 10);
    wr(A_CCLR, 1);
    rd(5'(A_MAX0 + 1), rv);
    check("R7 bit0 keeps max", rv, 10);
    wr(A_CCLR, 2);
    rd(5'(A_MAX0 + 1), rv);
    check("R7 bit1 clears max", rv, 0);

    // R9: global clear ordering
    @(negedge clk);
    base_cfg(32'h8020_0802, 32'h0101_0101);
    wr(A_IEN, 4'h2);
    wr(A_GEN, 1);
    run_windows(40, 1);
    check("R9 global set", 32'(irq_global), 1);
    wr(A_GCLR, 1);
    check("R9 global reasserts while local high", 32'(irq_global), 1);
    wr(A_ICLR, 4'hF);
    check("R9 global latched after local clear", 32'(irq_global), 1);
    wr(A_GCLR, 1);
    check("R9 global cleared", 32'(irq_global), 0);
    wr(A_GEN, 0);

    // R10: stopped monitor ignores traffic
    @(negedge clk);
    base_cfg(32'h8020_0802, 32'h0101_0101);
    xfer_bytes = 8'd255; xfer_valid = 1'b1;
    repeat (100) @(negedge clk);
    rd(A_IST, rv);
    check("R10 no status while stopped", rv, 0);
    rd(5'(A_MAX0 + 3), rv);
    check("R10 no max while stopped", rv, 0);

    // R8 collision: status clear on the classification edge; set wins
    @(negedge clk);
    base_cfg(32'h8020_0802, 32'h0101_0101);
    xfer_bytes = 8'd40; xfer_valid = 1'b1;
    wr(A_RUN, 1);
    repeat (WLEN) @(negedge clk);
    wr(A_ICLR, 4'hF);
    wr(A_RUN, 0);
    rd(A_IST, rv);
    check("R8 set beats same-cycle clear", rv, 32'h2);

    // R7 collision: counter clear on the classification edge drops the window
    @(negedge clk);
    base_cfg(32'h8020_0802, 32'h0101_0101);
    xfer_bytes = 8'd40; xfer_valid = 1'b1;
    wr(A_RUN, 1);
    repeat (WLEN) @(negedge clk);
    wr(A_CCLR, 1);
    wr(A_RUN, 0);
    rd(A_IST, rv);
    check("R7 clear drops pending status", rv, 0);
    rd(5'(A_MAX0 + 1), rv);
    check("R7 clear drops pending max", rv, 0);

    // R7/R8/R9: write-only addresses read zero
    rd(A_CCLR, rv);
    check("R7 counter clear reads zero", rv, 0);
    rd(A_ICLR, rv);
    check("R8 status clear reads zero", rv, 0);
    rd(A_GCLR, rv);
    check("R9 global clear reads zero", rv, 0);

    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule